// File: doc/BRIEF.md
# Sensor Polling Sequencer

This controller gathers one complete status snapshot from a board's sensors: a single temperature reading followed by a reading from each of eight ADC channels. It sits next to a shared 3-bit state register that its peer controllers also read and write. When that register moves into the query code (3'b100), the sequencer wakes up and issues nine read requests, one at a time, to a child serial-transfer engine. It turns each returned result into a write to the local storage registers. When the snapshot is complete, it writes the transmit code (3'b101) into the state register, which hands control to the status-transmit controller.

The child engine uses a single-cycle handshake. The sequencer raises `xfer_req` for one cycle, together with a device bit (`xfer_dev`: 0 selects the temperature sensor, 1 selects the ADC) and a 3-bit channel. The engine later returns a one-cycle `xfer_done` carrying 12 data bits and the 3-bit channel address that the ADC echoed back. An ADC result whose echoed address does not match the requested channel is replaced by the sentinel 12'hFFF. If the state register leaves the query code before the snapshot is complete, the poll is dropped and no hand-off takes place.

The sequence runs through these states:
- IDLE goes to TEMP_REQ on the entry pulse.
- TEMP_REQ goes to TEMP_WAIT.
- TEMP_WAIT goes to ADC_REQ on done.
- ADC_REQ goes to ADC_WAIT.
- ADC_WAIT goes back to ADC_REQ on done while the channel is not zero, and to HANDOFF on done at channel 0.
- HANDOFF goes to IDLE.
- Any state other than IDLE returns to IDLE when the state register no longer holds the query code.

Top module: `sensor_poll_seq`

## Requirements
- R1: A poll starts only in the cycle after `state_q` changes into 3'b100 from any other value. Staying at 3'b100 after a poll has finished does not start another poll.
- R2: A poll issues exactly nine `xfer_req` pulses, each one cycle long. The first pulse has `xfer_dev`=0 (temperature) and the rest have `xfer_dev`=1 (ADC). No request is issued while an earlier one is still waiting for its `xfer_done`.
- R3: ADC requests, and the ADC register writes that follow them, visit the channels in descending order: 7, 6, 5, 4, 3, 2, 1, 0.
- R4: In the cycle after an ADC `xfer_done`, `adc_we` is high for one cycle. In that cycle `adc_wa` equals the requested channel and `adc_wd` equals `xfer_data`, provided the echoed `xfer_addr` matches the channel.
- R5: In the cycle after the temperature `xfer_done`, `temp_we` is high for one cycle and `temp_wd` equals `xfer_data[9:0]`.
- R6: When the echoed `xfer_addr` differs from the requested ADC channel, that channel's write carries 12'hFFF.
- R7: In the cycle after the channel-0 `xfer_done`, which is the same cycle as the channel-0 write, `state_we` is high for one cycle and `state_wd` is 3'b101. This happens exactly once per poll.
- R8: If `state_q` leaves 3'b100 during a poll, the block returns to IDLE. It then issues no further requests, makes no further register writes and does not write the state register.
- R9: Reset is asynchronous and active-low. While `rst_n` is low, `xfer_req`, `temp_we`, `adc_we` and `state_we` are low.
- R10: An `xfer_done` that arrives while no request is outstanding produces no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_q | input | 3 | Current value of the shared state register |
| state_we | output | 1 | State register write strobe |
| state_wd | output | 3 | State register write data |
| xfer_req | output | 1 | One-cycle transfer request to the serial engine |
| xfer_dev | output | 1 | Target device: 0 temperature, 1 ADC |
| xfer_chan | output | 3 | Requested ADC channel |
| xfer_done | input | 1 | One-cycle completion from the serial engine |
| xfer_data | input | 12 | Returned conversion data |
| xfer_addr | input | 3 | Channel address echoed by the ADC |
| temp_we | output | 1 | Temperature register write strobe |
| temp_wd | output | 10 | Temperature register write data |
| adc_we | output | 1 | ADC register write strobe |
| adc_wa | output | 3 | ADC register address (channel) |
| adc_wd | output | 12 | ADC register write data |

## Verification
The bench builds the block with its default parameters: eight channels, 12-bit data, a 10-bit temperature field, and state codes 3'b100 and 3'b101. With these values the whole descending channel walk and the channel-0 hand-off can be observed at the ports. A behavioural engine model in the bench replies with a latency chosen by each vector, so requests are observed both with fast replies and with slow ones. Per-vector mismatch masks exercise the sentinel path on the first channel, the last channel and the channels in between. Directed tests abort a poll, keep the state register frozen at the query code, send stray completions, and reset the block asynchronously in the middle of a poll.

// File: rtl/spoll_pkg.sv
package spoll_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TEMP_REQ,
        S_TEMP_WAIT,
        S_ADC_REQ,
        S_ADC_WAIT,
        S_HANDOFF
    } poll_state_t;

    localparam logic DEV_TEMP = 1'b0;
    localparam logic DEV_ADC  = 1'b1;

endpackage

// File: rtl/spoll_entry_detect.sv
module spoll_entry_detect #(
    parameter int            SW         = 3,
    parameter logic [SW-1:0] QUERY_CODE = 3'b100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] state_q,
    output logic          active,
    output logic          start
);

    logic was_active;

    assign active = (state_q == QUERY_CODE);
    assign start  = active && !was_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            was_active <= 1'b0;
        end else begin
            was_active <= active;
        end
    end

endmodule

// File: rtl/spoll_fsm.sv
module spoll_fsm
    import spoll_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CHAN_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  logic              xfer_done,
    output logic              xfer_req,
    output logic              xfer_dev,
    output logic [CHAN_W-1:0] xfer_chan,
    output logic              cap_temp,
    output logic              cap_adc,
    output logic              handoff
);

    localparam logic [CHAN_W-1:0] TOP_CH = CHAN_W'(NUM_CH - 1);

    poll_state_t       state, state_nx;
    logic [CHAN_W-1:0] chan, chan_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            chan  <= '0;
        end else begin
            state <= state_nx;
            chan  <= chan_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        chan_nx  = chan;
        if (state != S_IDLE && !active) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        state_nx = S_TEMP_REQ;
                        chan_nx  = TOP_CH;
                    end
                end
                S_TEMP_REQ:  state_nx = S_TEMP_WAIT;
                S_TEMP_WAIT: if (xfer_done) state_nx = S_ADC_REQ;
                S_ADC_REQ:   state_nx = S_ADC_WAIT;
                S_ADC_WAIT: begin
                    if (xfer_done) begin
                        if (chan == '0) begin
                            state_nx = S_HANDOFF;
                        end else begin
                            state_nx = S_ADC_REQ;
                            chan_nx  = chan - 1'b1;
                        end
                    end
                end
                S_HANDOFF:   state_nx = S_IDLE;
                default:     state_nx = S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        xfer_req  = 1'b0;
        xfer_dev  = DEV_TEMP;
        xfer_chan = '0;
        cap_temp  = 1'b0;
        cap_adc   = 1'b0;
        handoff   = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_TEMP_REQ: xfer_req = active;
            S_TEMP_WAIT: cap_temp = active && xfer_done;
            S_ADC_REQ: begin
                xfer_req  = active;
                xfer_dev  = DEV_ADC;
                xfer_chan = chan;
            end
            S_ADC_WAIT: begin
                xfer_dev  = DEV_ADC;
                xfer_chan = chan;
                cap_adc   = active && xfer_done;
            end
            S_HANDOFF: handoff = active;
            default: ;
        endcase
    end

endmodule

// File: rtl/spoll_result_fmt.sv
module spoll_result_fmt #(
    parameter int DATA_W = 12,
    parameter int TEMP_W = 10,
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_temp,
    input  logic              cap_adc,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [CHAN_W-1:0] rx_addr,
    output logic              temp_we,
    output logic [TEMP_W-1:0] temp_wd,
    output logic              adc_we,
    output logic [CHAN_W-1:0] adc_wa,
    output logic [DATA_W-1:0] adc_wd
);

    localparam logic [DATA_W-1:0] SENTINEL = '1;

    logic echo_bad;
    assign echo_bad = (rx_addr != req_chan);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            temp_we <= 1'b0;
            temp_wd <= '0;
            adc_we  <= 1'b0;
            adc_wa  <= '0;
            adc_wd  <= '0;
        end else begin
            temp_we <= cap_temp;
            adc_we  <= cap_adc;
            if (cap_temp) begin
                temp_wd <= rx_data[TEMP_W-1:0];
            end
            if (cap_adc) begin
                adc_wa <= req_chan;
                adc_wd <= echo_bad ? SENTINEL : rx_data;
            end
        end
    end

endmodule

// File: rtl/sensor_poll_seq.sv
module sensor_poll_seq #(
    parameter int            NUM_CH     = 8,
    parameter int            DATA_W     = 12,
    parameter int            TEMP_W     = 10,
    parameter int            SW         = 3,
    parameter logic [SW-1:0] QUERY_CODE = 3'b100,
    parameter logic [SW-1:0] NEXT_CODE  = 3'b101,
    localparam int           CHAN_W     = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW-1:0]     state_q,
    output logic              state_we,
    output logic [SW-1:0]     state_wd,
    output logic              xfer_req,
    output logic              xfer_dev,
    output logic [CHAN_W-1:0] xfer_chan,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] xfer_data,
    input  logic [CHAN_W-1:0] xfer_addr,
    output logic              temp_we,
    output logic [TEMP_W-1:0] temp_wd,
    output logic              adc_we,
    output logic [CHAN_W-1:0] adc_wa,
    output logic [DATA_W-1:0] adc_wd
);

    logic active, start, cap_temp, cap_adc, handoff;

    spoll_entry_detect #(
        .SW(SW), .QUERY_CODE(QUERY_CODE)
    ) u_entry (
        .clk(clk), .rst_n(rst_n), .state_q(state_q),
        .active(active), .start(start)
    );

    spoll_fsm #(
        .NUM_CH(NUM_CH)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .active(active),
        .xfer_done(xfer_done), .xfer_req(xfer_req), .xfer_dev(xfer_dev),
        .xfer_chan(xfer_chan), .cap_temp(cap_temp), .cap_adc(cap_adc),
        .handoff(handoff)
    );

    spoll_result_fmt #(
        .DATA_W(DATA_W), .TEMP_W(TEMP_W), .CHAN_W(CHAN_W)
    ) u_fmt (
        .clk(clk), .rst_n(rst_n), .cap_temp(cap_temp), .cap_adc(cap_adc),
        .req_chan(xfer_chan), .rx_data(xfer_data), .rx_addr(xfer_addr),
        .temp_we(temp_we), .temp_wd(temp_wd), .adc_we(adc_we),
        .adc_wa(adc_wa), .adc_wd(adc_wd)
    );

    assign state_we = handoff;
    assign state_wd = handoff ? NEXT_CODE : '0;

endmodule

// File: rtl/spoll_checker.sv
module spoll_checker #(
    parameter int            SW         = 3,
    parameter logic [SW-1:0] QUERY_CODE = 3'b100
) (
    input logic          clk,
    input logic          rst_n,
    input logic [SW-1:0] state_q,
    input logic          state_we,
    input logic          xfer_req,
    input logic          xfer_done,
    input logic          temp_we,
    input logic          adc_we
);

    // outstanding-request tracker, cleared by completion or by leaving the query state
    logic pending;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    pending <= 1'b0;
        else if (xfer_done || state_q != QUERY_CODE)   pending <= 1'b0;
        else if (xfer_req)                             pending <= 1'b1;
    end

    assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> !xfer_req);

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !pending);

    assert_adc_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_we |=> !adc_we);

    assert_adc_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_we |-> $past(xfer_done));

    assert_temp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        temp_we |=> !temp_we);

    assert_handoff_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_we |=> !state_we);

    assert_handoff_in_query_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state_we |-> state_q == QUERY_CODE);

    assert_req_in_query_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> state_q == QUERY_CODE);

endmodule

bind sensor_poll_seq spoll_checker #(.SW(SW), .QUERY_CODE(QUERY_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .state_we(state_we),
    .xfer_req(xfer_req), .xfer_done(xfer_done), .temp_we(temp_we),
    .adc_we(adc_we)
);

// File: tb/test_sensor_poll_seq.sv
module test_sensor_poll_seq;

    localparam logic [2:0] QUERY = 3'b100;
    localparam logic [2:0] NEXT  = 3'b101;

    typedef struct packed {
        logic [11:0] temp;
        logic [11:0] base;
        logic [7:0]  bad;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{temp: 12'hABC, base: 12'h100, bad: 8'h00, lat: 4'd1},
        '{temp: 12'h3FF, base: 12'h7F0, bad: 8'h80, lat: 4'd3},
        '{temp: 12'hC01, base: 12'h020, bad: 8'h01, lat: 4'd2},
        '{temp: 12'h155, base: 12'hE00, bad: 8'h5A, lat: 4'd6},
        '{temp: 12'h000, base: 12'hFFE, bad: 8'hFF, lat: 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  state_q = 3'b000;
    logic        state_we;
    logic [2:0]  state_wd;
    logic        xfer_req, xfer_dev;
    logic [2:0]  xfer_chan;
    logic        xfer_done = 1'b0;
    logic [11:0] xfer_data = '0;
    logic [2:0]  xfer_addr = '0;
    logic        temp_we, adc_we;
    logic [9:0]  temp_wd;
    logic [2:0]  adc_wa;
    logic [11:0] adc_wd;

    sensor_poll_seq i_sensor_poll_seq (
        .clk(clk), .rst_n(rst_n), .state_q(state_q), .state_we(state_we),
        .state_wd(state_wd), .xfer_req(xfer_req), .xfer_dev(xfer_dev),
        .xfer_chan(xfer_chan), .xfer_done(xfer_done), .xfer_data(xfer_data),
        .xfer_addr(xfer_addr), .temp_we(temp_we), .temp_wd(temp_wd),
        .adc_we(adc_we), .adc_wa(adc_wa), .adc_wd(adc_wd)
    );

    always #10 clk = ~clk;

    int   errors = 0, checks = 0;
    int   req_cnt, temp_cnt, adc_cnt, state_cnt, dev_errs;
    logic last_done = 1'b0;
    logic follow = 1'b1;
    vec_t cur = '0;
    bit   done_flag = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] adc_val(input logic [2:0] c);
        return cur.base + 12'(int'(c) * 37);
    endfunction

    task automatic clear_counts();
        req_cnt = 0; temp_cnt = 0; adc_cnt = 0; state_cnt = 0; dev_errs = 0;
    endtask

    // engine model
    initial begin
        forever begin
            logic       d;
            logic [2:0] c;
            @(negedge clk);
            if (rst_n && xfer_req) begin
                d = xfer_dev;
                c = xfer_chan;
                repeat (int'(cur.lat)) @(posedge clk);
                #2;
                xfer_done = 1'b1;
                xfer_data = d ? adc_val(c) : cur.temp;
                xfer_addr = d ? (cur.bad[c] ? ~c : c) : 3'd0;
                @(posedge clk);
                #2;
                xfer_done = 1'b0;
            end
        end
    end

    // port monitor and state register model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (xfer_req) begin
                    req_cnt++;
                    if ((req_cnt == 1) != (xfer_dev == 1'b0)) dev_errs++;
                end
                if (temp_we) begin
                    temp_cnt++;
                    chk(temp_wd == cur.temp[9:0], "R5 temp data", temp_wd, cur.temp[9:0]);
                end
                if (adc_we) begin
                    logic [2:0] ec;
                    ec = 3'(7 - adc_cnt);
                    chk(last_done, "R4 write follows done", last_done, 1);
                    chk(adc_wa == ec, "R3 channel order", adc_wa, ec);
                    if (cur.bad[adc_wa])
                        chk(adc_wd == 12'hFFF, "R6 sentinel", adc_wd, 12'hFFF);
                    else
                        chk(adc_wd == adc_val(adc_wa), "R4 adc data", adc_wd, adc_val(adc_wa));
                    adc_cnt++;
                end
                if (state_we) begin
                    state_cnt++;
                    chk(state_wd == NEXT, "R7 handoff code", state_wd, NEXT);
                    chk(adc_cnt == 8, "R7 handoff after last channel", adc_cnt, 8);
                    if (follow) state_q = state_wd;
                end
            end
            last_done = xfer_done;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_handoff(input int limit);
        for (int k = 0; k < limit && state_cnt == 0; k++) @(negedge clk);
    endtask

    initial begin
        clear_counts();
        #5;
        // R9: reset values
        chk(!xfer_req && !temp_we && !adc_we && !state_we, "R9 reset idle",
            {xfer_req, temp_we, adc_we, state_we}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: stray completion while idle
        @(posedge clk); #2;
        xfer_done = 1'b1; xfer_data = 12'h123; xfer_addr = 3'd0;
        @(posedge clk); #2;
        xfer_done = 1'b0;
        repeat (5) @(negedge clk);
        chk(temp_cnt == 0 && adc_cnt == 0, "R10 stray done ignored", temp_cnt + adc_cnt, 0);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            clear_counts();
            cur = VECS[i];
            @(negedge clk);
            state_q = QUERY;
            wait_handoff(600);
            repeat (3) @(negedge clk);
            chk(req_cnt == 9, "R2 nine requests", req_cnt, 9);
            chk(dev_errs == 0, "R2 device order", dev_errs, 0);
            chk(temp_cnt == 1, "R5 one temp write", temp_cnt, 1);
            chk(adc_cnt == 8, "R4 eight adc writes", adc_cnt, 8);
            chk(state_cnt == 1, "R7 one handoff", state_cnt, 1);
            state_q = 3'b000;
            repeat (3) @(negedge clk);
        end

        // R8: abort mid-poll
        begin
            int snap;
            clear_counts();
            cur = VECS[1];
            @(negedge clk);
            state_q = QUERY;
            for (int k = 0; k < 200 && temp_cnt == 0; k++) @(negedge clk);
            state_q = 3'b010;
            snap = req_cnt;
            repeat (60) @(negedge clk);
            chk(state_cnt == 0, "R8 no handoff on abort", state_cnt, 0);
            chk(adc_cnt == 0, "R8 no adc write on abort", adc_cnt, 0);
            chk(req_cnt == snap, "R8 no request after abort", req_cnt, snap);
        end

        // R1: frozen state register does not retrigger
        clear_counts();
        follow = 1'b0;
        cur = VECS[0];
        state_q = QUERY;
        wait_handoff(600);
        repeat (100) @(negedge clk);
        chk(req_cnt == 9, "R1 no restart while held", req_cnt, 9);
        chk(state_cnt == 1, "R1 single handoff while held", state_cnt, 1);
        state_q = 3'b000;
        follow = 1'b1;
        repeat (3) @(negedge clk);

        // R9: asynchronous reset mid-poll
        clear_counts();
        cur = VECS[3];
        state_q = QUERY;
        for (int k = 0; k < 400 && req_cnt < 3; k++) @(negedge clk);
        #3;
        rst_n = 1'b0;
        #1;
        chk(!xfer_req && !temp_we && !adc_we && !state_we, "R9 async reset",
            {xfer_req, temp_we, adc_we, state_we}, 0);
        state_q = 3'b000;
        repeat (20) @(negedge clk);
        chk(!xfer_req && !adc_we, "R9 held in reset", {xfer_req, adc_we}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule